// File: doc/BRIEF.md
# UART Task/Event Control Front End

This block is the register-side control core of a byte-oriented UART. Software talks to it through a word-addressed register bus. It starts and stops the transmit and receive paths by writing tasks. It observes progress through event flags, and a masked level interrupt collects those flags. Serialization, baud timing and pin routing are outside the block. On the line side it offers one byte at a time to a transmitter with a valid/accept pair. It takes bytes from a receiver with a valid/ready pair into a six-entry circular buffer. A break strobe from the line feeds the error logic.

The peripheral powers up off. Only the magic value 4 in the enable register switches it on. The control logic is organised as four small state machines:

- **Peripheral FSM** (`PER_OFF`, `PER_ON`):
  - `PER_OFF -> PER_ON` on an enable write of 4.
  - `PER_ON -> PER_OFF` on an enable write of 0.
- **Receive run state** (`RUN_STOPPED`, `RUN_ACTIVE`):
  - `RUN_STOPPED -> RUN_ACTIVE` on a receive-go write of 1.
  - `RUN_ACTIVE -> RUN_STOPPED` on a receive-halt write, a pause write or a disable.
- **Transmit run state** (`RUN_STOPPED`, `RUN_ACTIVE`):
  - `RUN_STOPPED -> RUN_ACTIVE` on a transmit-go write of 1.
  - `RUN_ACTIVE -> RUN_STOPPED` on a transmit-halt write, a pause write or a disable.
- **Transmit queue** (`TXQ_IDLE`, `TXQ_HOLD`):
  - `TXQ_IDLE -> TXQ_HOLD` when a transmit data write is accepted.
  - `TXQ_HOLD -> TXQ_IDLE` when the line accepts the byte.

Word addresses:

| Address | Register | Address | Register |
|---|---|---|---|
| 0x00 | receive-go | 0x0A | mask-set |
| 0x01 | receive-halt | 0x0B | mask-clear |
| 0x02 | transmit-go | 0x0C | error source |
| 0x03 | transmit-halt | 0x0D | enable |
| 0x04 | pause | 0x0E | receive data |
| 0x05 | receive-ready event | 0x0F | transmit data |
| 0x06 | transmit-ready event | 0x10 | baud |
| 0x07 | error event | 0x11 | pin select 0 |
| 0x08 | receive-timeout event | 0x12 | pin select 1 |
| 0x09 | mask | 0x13 | pin select 2 |
| | | 0x14 | pin select 3 |

Task registers, the receive data register when written, and unmapped addresses read as 0. Writes to those addresses are ignored.

Top module: `uart_task_regs`

## Requirements
- R1: Writing 4 to enable (0x0D) turns the block on. Writing 0 turns it off, stops both the transmit and receive run states, and sets the receive-timeout event (0x08) to 1. Any other value leaves every state unchanged.
- R2: While off, `bus_rdata` is 0 for every address, and every write other than to 0x0D is ignored.
- R3: `irq` is the OR of four terms, each being an event that is nonzero AND its mask bit. Mask bit 0 belongs to receive-ready, bit 1 to transmit-ready, bit 2 to error and bit 3 to receive-timeout.
- R4: A write to 0x09 replaces the mask. A write to 0x0A ORs the data into the mask. A write to 0x0B clears the mask bits that are 1 in the data. Reading 0x09, 0x0A or 0x0B returns the mask.
- R5: Writing exactly 1 to 0x00 starts receive, and writing exactly 1 to 0x02 starts transmit. Any other value written there has no effect.
- R6: Writing 1 to 0x03 stops only transmit. Writing 1 to 0x01 stops receive and sets receive-timeout. Writing 1 to 0x04 stops both and sets receive-timeout.
- R7: A write to 0x0F is taken only while transmit runs and no byte is held. Otherwise it is dropped. A taken byte appears on `tx_byte` with `tx_valid` high and stays unchanged until `tx_accept`. The accept ends the hold and sets the transmit-ready event (0x06) to 1.
- R8: Reading 0x0E returns the oldest buffered byte in bits 7:0. The byte is removed only if receive runs and the buffer is not empty. If bytes remain after the removal, receive-ready is set to 1.
- R9: Receive-ready (0x05) reads 0 or 1. It is cleared only by writing 0, and any other written value is ignored. Events 0x06, 0x07 and 0x08 store the written value.
- R10: Error source (0x0C) clears the bits written as 1. A `line_break` pulse sets its bits 1:0 and sets the error event to 1.
- R11: After reset the block is off, both run states are stopped and the buffer is empty. Pin selects read 0xFFFFFFFF, baud reads 0x04000000, and every other register reads 0.
- R12: `rx_ready` is high only while receive runs and fewer than 6 bytes are held. Each taken byte sets receive-ready. Bytes leave the buffer in arrival order, and a full buffer never loses a held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (a read of 0x0E may pop) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | A byte is held for the transmitter |
| tx_accept | input | 1 | Transmitter takes the held byte |
| rx_byte | input | 8 | Byte from the receiver |
| rx_valid | input | 1 | Receiver presents a byte |
| rx_ready | output | 1 | Buffer will take the presented byte |
| line_break | input | 1 | Break detected on the line, one-cycle strobe |

## Verification
A wrong run state shows at the ports within one cycle:
- `rx_ready` drops or stays high.
- A transmit data write fails to raise `tx_valid` on the next cycle, or raises it when it should not.

A buffer pointer or count fault shows on the next read of 0x0E as a byte out of order. It also shows as `rx_ready` going the wrong way at the full boundary, or as receive-ready not re-firing after a pop.

Mask and event faults appear on `irq` in the cycle after the write. The sweep covers all combinations of mask and writable events.

// File: rtl/uart_tr_pkg.sv
package uart_tr_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_RX_GO    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RX_HALT  = 5'h01;
    localparam logic [ADDR_W-1:0] OFS_TX_GO    = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_TX_HALT  = 5'h03;
    localparam logic [ADDR_W-1:0] OFS_PAUSE    = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_EV_RXRDY = 5'h05;
    localparam logic [ADDR_W-1:0] OFS_EV_TXRDY = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_EV_ERR   = 5'h07;
    localparam logic [ADDR_W-1:0] OFS_EV_RXTMO = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_IMASK    = 5'h09;
    localparam logic [ADDR_W-1:0] OFS_IMASK_S  = 5'h0A;
    localparam logic [ADDR_W-1:0] OFS_IMASK_C  = 5'h0B;
    localparam logic [ADDR_W-1:0] OFS_ERRSRC   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 5'h0D;
    localparam logic [ADDR_W-1:0] OFS_RXDATA   = 5'h0E;
    localparam logic [ADDR_W-1:0] OFS_TXDATA   = 5'h0F;
    localparam logic [ADDR_W-1:0] OFS_BAUD     = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_PIN0     = 5'h11;

    localparam logic [BUS_W-1:0] ENABLE_KEY = 32'd4;
    localparam logic [BUS_W-1:0] BAUD_RST   = 32'h0400_0000;
    localparam logic [BUS_W-1:0] PIN_RST    = 32'hFFFF_FFFF;

    // event index = interrupt mask bit position
    localparam int EVI_RXRDY = 0;
    localparam int EVI_TXRDY = 1;
    localparam int EVI_ERR   = 2;
    localparam int EVI_RXTMO = 3;
    localparam int NUM_EV    = 4;

    typedef enum logic {PER_OFF, PER_ON} per_state_e;
    typedef enum logic {RUN_STOPPED, RUN_ACTIVE} run_state_e;
    typedef enum logic {TXQ_IDLE, TXQ_HOLD} txq_state_e;

endpackage

// File: rtl/uart_tr_rxbuf.sv
module uart_tr_rxbuf #(
    parameter int DEPTH  = 6,
    parameter int BYTE_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic [BYTE_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_data = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_tr_txq.sv
module uart_tr_txq
    import uart_tr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              line_accept,
    output logic [BYTE_W-1:0] line_byte,
    output logic              line_valid,
    output logic              busy,
    output logic              done
);

    txq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXQ_IDLE: if (load)        state_d = TXQ_HOLD;
            TXQ_HOLD: if (line_accept) state_d = TXQ_IDLE;
            default:                   state_d = TXQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            line_byte <= '0;
        else if (load && state_q == TXQ_IDLE)  line_byte <= load_data;
    end

    always_comb begin
        line_valid = (state_q == TXQ_HOLD);
        busy       = line_valid;
        done       = line_valid && line_accept;
    end

endmodule

// File: rtl/uart_tr_irqmux.sv
module uart_tr_irqmux #(
    parameter int N = 4
) (
    input  logic [N-1:0] ev_live,
    input  logic [N-1:0] ev_mask,
    output logic         irq
);

    logic [N-1:0] term;

    for (genvar g = 0; g < N; g++) begin : g_term
        assign term[g] = ev_live[g] & ev_mask[g];
    end

    assign irq = |term;

endmodule

// File: rtl/uart_task_regs.sv
module uart_task_regs
    import uart_tr_pkg::*;
#(
    parameter int RX_DEPTH = 6,
    parameter int BYTE_W   = 8,
    parameter int NUM_PINS = 4,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_accept,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              line_break
);

    per_state_e per_q, per_d;
    run_state_e rx_run_q, rx_run_d, tx_run_q, tx_run_d;

    logic             ev_rxrdy_q;
    logic [BUS_W-1:0] ev_txrdy_q, ev_err_q, ev_rxtmo_q;
    logic [BUS_W-1:0] imask_q, errsrc_q, baud_q;
    logic [BUS_W-1:0] pin_q [NUM_PINS];

    logic              per_on, rx_active, wr_ok, rd_ok, val_one, rxtmo_raise;
    logic              push, pop, refire, tx_load, tx_busy, tx_done;
    logic [BYTE_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_count;
    logic              rx_full, rx_empty;
    logic [BUS_W-1:0]  imask;

    assign per_on    = (per_q == PER_ON);
    assign rx_active = (rx_run_q == RUN_ACTIVE);
    assign imask     = imask_q;
    assign wr_ok     = bus_we && (per_on || bus_addr == OFS_ENABLE);
    assign rd_ok     = bus_re && per_on;
    assign val_one   = (bus_wdata == BUS_W'(1));

    // ---------------- control state machines: next state ----------------
    always_comb begin
        per_d       = per_q;
        rx_run_d    = rx_run_q;
        tx_run_d    = tx_run_q;
        rxtmo_raise = 1'b0;
        if (wr_ok) begin
            unique case (bus_addr)
                OFS_ENABLE: begin
                    if (bus_wdata == ENABLE_KEY) begin
                        per_d = PER_ON;
                    end else if (bus_wdata == '0) begin
                        per_d       = PER_OFF;
                        rx_run_d    = RUN_STOPPED;
                        tx_run_d    = RUN_STOPPED;
                        rxtmo_raise = 1'b1;
                    end
                end
                OFS_PAUSE: if (val_one) begin
                    rx_run_d    = RUN_STOPPED;
                    tx_run_d    = RUN_STOPPED;
                    rxtmo_raise = 1'b1;
                end
                OFS_RX_HALT: if (val_one) begin
                    rx_run_d    = RUN_STOPPED;
                    rxtmo_raise = 1'b1;
                end
                OFS_TX_HALT: if (val_one) tx_run_d = RUN_STOPPED;
                OFS_RX_GO:   if (val_one) rx_run_d = RUN_ACTIVE;
                OFS_TX_GO:   if (val_one) tx_run_d = RUN_ACTIVE;
                default: ;
            endcase
        end
    end

    // ---------------- control state machines: state registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q    <= PER_OFF;
            rx_run_q <= RUN_STOPPED;
            tx_run_q <= RUN_STOPPED;
        end else begin
            per_q    <= per_d;
            rx_run_q <= rx_run_d;
            tx_run_q <= tx_run_d;
        end
    end

    // ---------------- data paths ----------------
    assign rx_ready = rx_active && !rx_full;
    assign push     = rx_valid && rx_ready;
    assign pop      = rd_ok && (bus_addr == OFS_RXDATA) && rx_active && !rx_empty;
    assign refire   = pop && (rx_count > CNT_W'(1));
    assign tx_load  = wr_ok && (bus_addr == OFS_TXDATA) && (tx_run_q == RUN_ACTIVE) && !tx_busy;

    uart_tr_rxbuf #(.DEPTH(RX_DEPTH), .BYTE_W(BYTE_W)) rxbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_byte),
        .pop       (pop),
        .head_data (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    uart_tr_txq #(.BYTE_W(BYTE_W)) txq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (tx_load),
        .load_data   (bus_wdata[BYTE_W-1:0]),
        .line_accept (tx_accept),
        .line_byte   (tx_byte),
        .line_valid  (tx_valid),
        .busy        (tx_busy),
        .done        (tx_done)
    );

    // ---------------- events, mask, stored registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_rxrdy_q <= 1'b0;
            ev_txrdy_q <= '0;
            ev_err_q   <= '0;
            ev_rxtmo_q <= '0;
            imask_q    <= '0;
            errsrc_q   <= '0;
            baud_q     <= BAUD_RST;
            for (int p = 0; p < NUM_PINS; p++) pin_q[p] <= PIN_RST;
        end else begin
            if (wr_ok) begin
                unique case (bus_addr)
                    OFS_EV_RXRDY: if (bus_wdata == '0) ev_rxrdy_q <= 1'b0;
                    OFS_EV_TXRDY: ev_txrdy_q <= bus_wdata;
                    OFS_EV_ERR:   ev_err_q   <= bus_wdata;
                    OFS_EV_RXTMO: ev_rxtmo_q <= bus_wdata;
                    OFS_IMASK:    imask_q    <= bus_wdata;
                    OFS_IMASK_S:  imask_q    <= imask_q | bus_wdata;
                    OFS_IMASK_C:  imask_q    <= imask_q & ~bus_wdata;
                    OFS_ERRSRC:   errsrc_q   <= errsrc_q & ~bus_wdata;
                    OFS_BAUD:     baud_q     <= bus_wdata;
                    default: begin
                        for (int p = 0; p < NUM_PINS; p++)
                            if (bus_addr == OFS_PIN0 + ADDR_W'(p)) pin_q[p] <= bus_wdata;
                    end
                endcase
            end
            // hardware-side set terms take precedence over same-cycle writes
            if (push || refire) ev_rxrdy_q <= 1'b1;
            if (tx_done)        ev_txrdy_q <= BUS_W'(1);
            if (rxtmo_raise)    ev_rxtmo_q <= BUS_W'(1);
            if (line_break) begin
                ev_err_q <= BUS_W'(1);
                if (wr_ok && bus_addr == OFS_ERRSRC)
                    errsrc_q <= (errsrc_q & ~bus_wdata) | BUS_W'(3);
                else
                    errsrc_q <= errsrc_q | BUS_W'(3);
            end
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (per_on) begin
            unique case (bus_addr)
                OFS_EV_RXRDY: bus_rdata = BUS_W'(ev_rxrdy_q);
                OFS_EV_TXRDY: bus_rdata = ev_txrdy_q;
                OFS_EV_ERR:   bus_rdata = ev_err_q;
                OFS_EV_RXTMO: bus_rdata = ev_rxtmo_q;
                OFS_IMASK, OFS_IMASK_S, OFS_IMASK_C: bus_rdata = imask_q;
                OFS_ERRSRC:   bus_rdata = errsrc_q;
                OFS_RXDATA:   bus_rdata = BUS_W'(rx_head);
                OFS_BAUD:     bus_rdata = baud_q;
                default: begin
                    for (int p = 0; p < NUM_PINS; p++)
                        if (bus_addr == OFS_PIN0 + ADDR_W'(p)) bus_rdata = pin_q[p];
                end
            endcase
        end
    end

    // ---------------- interrupt ----------------
    logic [NUM_EV-1:0] ev_live;
    always_comb begin
        ev_live            = '0;
        ev_live[EVI_RXRDY] = ev_rxrdy_q;
        ev_live[EVI_TXRDY] = (ev_txrdy_q != '0);
        ev_live[EVI_ERR]   = (ev_err_q != '0);
        ev_live[EVI_RXTMO] = (ev_rxtmo_q != '0);
    end

    uart_tr_irqmux #(.N(NUM_EV)) irqmux_i (
        .ev_live (ev_live),
        .ev_mask (imask_q[NUM_EV-1:0]),
        .irq     (irq)
    );

endmodule

// File: rtl/uart_tr_chk.sv
module uart_tr_chk
    import uart_tr_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              irq,
    input logic              tx_valid,
    input logic              tx_accept,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              rx_ready,
    input logic              per_on,
    input logic              rx_active,
    input logic [CNT_W-1:0]  rx_count,
    input logic [BUS_W-1:0]  imask
);

    // R1
    enable_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ENABLE && bus_wdata == ENABLE_KEY) |=> per_on);

    // R2
    off_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !per_on |-> (bus_rdata == '0));

    // R3
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imask[NUM_EV-1:0] == '0) |-> !irq);

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_accept) |=> (tx_valid && $stable(tx_byte)));

    // R12
    rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_W'(DEPTH));

    // R12
    rx_full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CNT_W'(DEPTH)) |-> !rx_ready);

    // R12
    rx_ready_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rx_active);

endmodule

bind uart_task_regs uart_tr_chk #(.DEPTH(RX_DEPTH), .BYTE_W(BYTE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tx_valid  (tx_valid),
    .tx_accept (tx_accept),
    .tx_byte   (tx_byte),
    .rx_ready  (rx_ready),
    .per_on    (per_on),
    .rx_active (rx_active),
    .rx_count  (rx_count),
    .imask     (imask)
);

// File: tb/uart_task_regs_tb.sv
module uart_task_regs_tb_top;
    import uart_tr_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0, bus_re = 1'b0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic              irq, tx_valid, rx_ready;
    logic [7:0]        tx_byte;
    logic              tx_accept = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic              rx_valid = 1'b0;
    logic              line_break = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] q [$];

    always #5 clk = ~clk;

    uart_task_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .tx_accept(tx_accept), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .line_break(line_break)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, output logic took);
        rx_byte = b; rx_valid = 1'b1;
        #1 took = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
        if (took) q.push_back(b);
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        #(10 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic took;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R2: reset state, off
        chk("R11 irq", irq, 0);
        chk("R11 tx_valid", tx_valid, 0);
        chk("R11 rx_ready", rx_ready, 0);
        rd_chk("R2 off read pin", OFS_PIN0, 0);
        rd_chk("R2 off read baud", OFS_BAUD, 0);
        wr(OFS_ENABLE, 4);
        rd_chk("R11 baud", OFS_BAUD, 32'h0400_0000);
        for (int p = 0; p < 4; p++) rd_chk("R11 pin", OFS_PIN0 + ADDR_W'(p), 32'hFFFF_FFFF);
        rd_chk("R11 mask", OFS_IMASK, 0);
        rd_chk("R11 errsrc", OFS_ERRSRC, 0);
        rd_chk("R11 ev_rxtmo", OFS_EV_RXTMO, 0);
        rd_chk("R11 ev_txrdy", OFS_EV_TXRDY, 0);

        // R1 / R2: disable, writes ignored while off
        wr(OFS_TX_GO, 1);
        wr(OFS_ENABLE, 0);
        wr(OFS_IMASK, 32'hF);
        wr(OFS_BAUD, 32'h1234);
        wr(OFS_TX_GO, 1);
        rd_chk("R2 off mask read", OFS_IMASK, 0);
        chk("R2 off irq", irq, 0);
        wr(OFS_ENABLE, 4);
        rd_chk("R2 mask write ignored", OFS_IMASK, 0);
        rd_chk("R2 baud write ignored", OFS_BAUD, 32'h0400_0000);
        rd_chk("R1 disable raises rxtmo", OFS_EV_RXTMO, 1);
        wr(OFS_TXDATA, 8'h77);
        chk("R1 disable stopped tx", tx_valid, 0);
        wr(OFS_EV_RXTMO, 0);

        // R1 sweep of other enable values
        for (int v = 1; v < 16; v++) begin
            if (v == 4) continue;
            wr(OFS_ENABLE, 32'(v));
            rd_chk("R1 other value keeps on", OFS_BAUD, 32'h0400_0000);
        end
        rd_chk("R1 no rxtmo from other values", OFS_EV_RXTMO, 0);
        wr(OFS_ENABLE, 0);
        for (int v = 1; v < 16; v++) begin
            if (v == 4) continue;
            wr(OFS_ENABLE, 32'(v));
            rd_chk("R1 other value keeps off", OFS_BAUD, 0);
        end
        wr(OFS_ENABLE, 4);
        wr(OFS_EV_RXTMO, 0);

        // R9 event register semantics
        wr(OFS_EV_TXRDY, 5);
        rd_chk("R9 txrdy stores", OFS_EV_TXRDY, 5);
        wr(OFS_EV_ERR, 7);
        rd_chk("R9 err stores", OFS_EV_ERR, 7);
        wr(OFS_EV_RXTMO, 32'hA0);
        rd_chk("R9 rxtmo stores", OFS_EV_RXTMO, 32'hA0);
        wr(OFS_EV_RXRDY, 1);
        rd_chk("R9 rxrdy not set by write", OFS_EV_RXRDY, 0);
        wr(OFS_EV_TXRDY, 0); wr(OFS_EV_ERR, 0); wr(OFS_EV_RXTMO, 0);

        // R4 mask sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int c;
                c = (b + 3) & 15;
                wr(OFS_IMASK, 32'(a));
                wr(OFS_IMASK_S, 32'(b));
                rd_chk("R4 set alias", OFS_IMASK_S, 32'(a | b));
                wr(OFS_IMASK_C, 32'(c));
                rd_chk("R4 clear alias", OFS_IMASK_C, 32'((a | b) & ~c & 15));
            end
        end

        // R3 irq sweep over writable events
        for (int m = 0; m < 16; m++) begin
            for (int e = 0; e < 8; e++) begin
                wr(OFS_IMASK, 32'(m));
                wr(OFS_EV_TXRDY, 32'(e & 1));
                wr(OFS_EV_ERR, 32'((e >> 1) & 1) << 4);
                wr(OFS_EV_RXTMO, 32'((e >> 2) & 1));
                chk("R3 irq", irq, ((m >> 1) & e) != 0);
            end
        end
        wr(OFS_EV_TXRDY, 0); wr(OFS_EV_ERR, 0); wr(OFS_EV_RXTMO, 0);

        // R5 non-1 values ignored
        wr(OFS_TX_GO, 3);
        wr(OFS_TXDATA, 8'h11);
        chk("R5 tx_go 3 ignored", tx_valid, 0);
        wr(OFS_RX_GO, 2);
        chk("R5 rx_go 2 ignored", rx_ready, 0);

        // R3 rx-ready term, R12 push sets event
        wr(OFS_RX_GO, 1);
        chk("R5 rx_go 1 starts", rx_ready, 1);
        wr(OFS_IMASK, 1);
        push(8'h5A, took);
        chk("R12 push sets rxrdy -> irq", irq, 1);
        wr(OFS_IMASK, 32'hE);
        chk("R3 rxrdy masked", irq, 0);
        wr(OFS_EV_RXRDY, 0);
        rd_chk("R8 single byte", OFS_RXDATA, 32'h5A);
        void'(q.pop_front());
        rd_chk("R8 no refire when empty", OFS_EV_RXRDY, 0);
        wr(OFS_IMASK, 0);

        // R12 fill beyond capacity, R8 pop order and refire
        for (int i = 0; i < 8; i++) begin
            push(8'h40 + 8'(i), took);
            chk("R12 accept while space", took, i < 6);
        end
        for (int k = 0; k < 6; k++) begin
            wr(OFS_EV_RXRDY, 0);
            rd_chk("R8 fifo order", OFS_RXDATA, 32'(q.pop_front()));
            rd_chk("R8 refire", OFS_EV_RXRDY, k < 5);
        end
        chk("R12 ready after drain", rx_ready, 1);

        // R12 wrap-around
        for (int i = 0; i < 4; i++) push(8'h60 + 8'(i), took);
        for (int k = 0; k < 2; k++) rd_chk("R12 wrap pop", OFS_RXDATA, 32'(q.pop_front()));
        for (int i = 0; i < 4; i++) begin
            push(8'h70 + 8'(i), took);
            chk("R12 wrap accept", took, 1);
        end
        push(8'h99, took);
        chk("R12 full refuses", took, 0);
        for (int k = 0; k < 6; k++) rd_chk("R12 wrap order", OFS_RXDATA, 32'(q.pop_front()));

        // R8 / R6: no pop while stopped, rx halt raises timeout
        push(8'h81, took); push(8'h82, took);
        wr(OFS_RX_HALT, 1);
        chk("R6 rx halt drops ready", rx_ready, 0);
        rd_chk("R6 rx halt rxtmo", OFS_EV_RXTMO, 1);
        rd_chk("R8 stopped read", OFS_RXDATA, 32'h81);
        rd_chk("R8 stopped no pop", OFS_RXDATA, 32'h81);
        wr(OFS_RX_GO, 1);
        rd_chk("R8 pop after restart", OFS_RXDATA, 32'(q.pop_front()));
        rd_chk("R8 pop last", OFS_RXDATA, 32'(q.pop_front()));
        wr(OFS_EV_RXTMO, 0);

        // R7 transmit path
        wr(OFS_TX_GO, 1);
        wr(OFS_TXDATA, 8'hC3);
        chk("R7 tx valid", tx_valid, 1);
        chk("R7 tx byte", tx_byte, 8'hC3);
        wr(OFS_TXDATA, 8'h3C);
        chk("R7 pending write dropped", tx_byte, 8'hC3);
        repeat (3) @(negedge clk);
        chk("R7 held", tx_valid, 1);
        rd_chk("R7 no event before accept", OFS_EV_TXRDY, 0);
        tx_accept = 1'b1;
        @(negedge clk);
        tx_accept = 1'b0;
        chk("R7 released", tx_valid, 0);
        rd_chk("R7 txrdy set", OFS_EV_TXRDY, 1);
        wr(OFS_TXDATA, 8'h3C);
        chk("R7 next byte", tx_byte, 8'h3C);
        tx_accept = 1'b1; @(negedge clk); tx_accept = 1'b0;

        // R6 tx halt leaves rx, pause stops both
        wr(OFS_TX_HALT, 1);
        wr(OFS_TXDATA, 8'h55);
        chk("R6 tx halt", tx_valid, 0);
        chk("R6 tx halt keeps rx", rx_ready, 1);
        rd_chk("R6 tx halt no rxtmo", OFS_EV_RXTMO, 0);
        wr(OFS_TX_GO, 1);
        wr(OFS_PAUSE, 1);
        wr(OFS_TXDATA, 8'h55);
        chk("R6 pause stops tx", tx_valid, 0);
        chk("R6 pause stops rx", rx_ready, 0);
        rd_chk("R6 pause rxtmo", OFS_EV_RXTMO, 1);

        // R10 error source and break
        line_break = 1'b1; @(negedge clk); line_break = 1'b0;
        rd_chk("R10 break errsrc", OFS_ERRSRC, 3);
        rd_chk("R10 break event", OFS_EV_ERR, 1);
        wr(OFS_IMASK, 4);
        chk("R10 break irq", irq, 1);
        wr(OFS_ERRSRC, 1);
        rd_chk("R10 w1c bit0", OFS_ERRSRC, 2);
        wr(OFS_ERRSRC, 2);
        rd_chk("R10 w1c bit1", OFS_ERRSRC, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule